// File: doc/BRIEF.md
# Round-Key Expansion Engine

This block turns a cipher key of 128, 192 or 256 bits into the complete list of 32-bit round-key words used by the standard 128-bit-block cipher with 10, 12 or 14 rounds. It produces one word per clock into an internal word store. The rest of the chip reads that store through an indexed, combinational read port once the engine reports completion.

A mode input picks the key order. In encryption order the store holds the plain expanded schedule. In decryption order the engine makes a second pass over the store and runs every middle round key through the inverse column-mixing transform. That is the schedule the equivalent inverse cipher needs. The substitution box is built in logic as the multiplicative inverse in GF(2^8), reduced by x^8+x^4+x^3+x+1, followed by the affine map. No table is stored.

A run begins with a one-cycle `start` while the engine is idle. The key, size and mode are captured at that edge. `busy` stays high until the run finishes, and then `done` pulses for one cycle.

Top module: `aes_key_schedule`

## Requirements
- R1: `key_size` 0 selects Nk=4 (10 rounds), 1 selects Nk=6 (12 rounds), and 2 or 3 select Nk=8 (14 rounds). A run writes exactly 4*(Nr+1) words: 44, 52 or 60.
- R2: Word j for j<Nk equals `key_in[255-32*j -: 32]`. The key is left-aligned in `key_in`, and the first key byte is the most significant byte of word 0.
- R3: For word i>=Nk with i mod Nk = 0, the engine rotates word i-1 left by one byte and substitutes each byte. It then XORs in a round constant in the top byte, with the low three bytes zero. The constant is 0x01 on first use and is multiplied by x (xtime) on each later use.
- R4: Only with Nk=8, a word with i mod 8 = 4 takes byte substitution of word i-1 without rotation and without the round constant.
- R5: Every other word i>=Nk is W[i-Nk] XOR W[i-1]. The substitution maps 0x00 to 0x63, so an all-zero 128-bit key gives word 4 = 0x62636363.
- R6: With `decrypt`=1, words 4 through 4*Nr-1 are replaced by their inverse column mix, using coefficients 0e,0b,0d,09 with byte 0 as the most significant byte. The first and the last round keys stay as in encryption order.
- R7: `busy` rises in the cycle after the start edge. `done` appears 4*Nr+4 clock edges after the start edge in encryption order, and 8*Nr edges after it in decryption order.
- R8: `start` has no effect while `busy` is high. The key, size and mode of the running job are kept.
- R9: `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R10: After reset `busy` and `done` are low. `rd_word` shows stored word `rd_idx` in the same cycle.
- R11: The standard test keys end in 0xb6630ca6 (word 43), 0x01002202 (word 51) and 0x706c631e (word 59).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; taken only when not busy |
| key_size | input | 2 | Key length select (see R1) |
| decrypt | input | 1 | 1 = decryption-order schedule |
| key_in | input | 256 | Cipher key, left-aligned |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_idx | input | 6 | Word index for the read port |
| rd_word | output | 32 | Stored round-key word at `rd_idx` |

## Verification
Completion is due 44, 52 or 60 edges after the start edge in encryption order, and 80, 96 or 112 edges after it in decryption order; `busy` is high for every cycle before that. The bench keeps a behavioural countdown started from the same sampled `start`, and compares `busy` and `done` against it at every falling edge, so an early, late or stretched pulse is caught in the exact cycle. Word contents are compared only after `done`, through the combinational read port, against a schedule the bench builds from the requirements with its own field arithmetic.

// File: rtl/aes_ks_pkg.sv
`timescale 1ns/1ps
package aes_ks_pkg;

    localparam int BYTE_W      = 8;
    localparam int WORD_W      = 32;
    localparam int MAX_NK      = 8;
    localparam int MAX_NR      = MAX_NK + 6;
    localparam int ROUND_WORDS = 4;
    localparam int MAX_WORDS   = ROUND_WORDS * (MAX_NR + 1);
    localparam int IDX_W       = $clog2(MAX_WORDS);
    localparam int POS_W       = $clog2(MAX_NK);
    localparam int NK_W        = $clog2(MAX_NK + 1);
    localparam int KEY_W       = MAX_NK * WORD_W;
    localparam int IMC_FIRST   = ROUND_WORDS;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam byte_t RCON_FIRST = 8'h01;
    localparam byte_t AFFINE_C   = 8'h63;

    typedef enum logic [2:0] {
        KS_IDLE,
        KS_LOAD,
        KS_EXPAND,
        KS_IMC,
        KS_DONE
    } ks_state_e;

    typedef struct packed {
        logic [NK_W-1:0]  nk;
        logic [IDX_W-1:0] total;
    } ks_geom_t;

    function automatic ks_geom_t geom_of(input logic [1:0] sel);
        ks_geom_t g;
        int nk;
        case (sel)
            2'd0:    nk = 4;
            2'd1:    nk = 6;
            default: nk = MAX_NK;
        endcase
        g.nk    = NK_W'(nk);
        g.total = IDX_W'(ROUND_WORDS * (nk + 6 + 1));
        return g;
    endfunction

    function automatic byte_t xtime(input byte_t b);
        return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t p;
        byte_t s;
        p = '0;
        s = a;
        for (int k = 0; k < BYTE_W; k++) begin
            if (b[k]) p = p ^ s;
            s = xtime(s);
        end
        return p;
    endfunction

    // a^254 is the inverse for a != 0 and yields 0 for a == 0
    function automatic byte_t gf_inv(input byte_t a);
        byte_t sq;
        byte_t r;
        sq = a;
        r  = 8'h01;
        for (int k = 1; k < BYTE_W; k++) begin
            sq = gf_mul(sq, sq);
            r  = gf_mul(r, sq);
        end
        return r;
    endfunction

    function automatic byte_t sbox(input byte_t b);
        byte_t v;
        v = gf_inv(b);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^
               {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]} ^ AFFINE_C;
    endfunction

    function automatic word_t rot_word(input word_t w);
        return {w[WORD_W-BYTE_W-1:0], w[WORD_W-1 -: BYTE_W]};
    endfunction

endpackage

// File: rtl/aes_ks_subword.sv
`timescale 1ns/1ps
module aes_ks_subword
    import aes_ks_pkg::*;
(
    input  word_t in_w,
    output word_t out_w
);
    localparam int LANES = WORD_W / BYTE_W;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign out_w[b*BYTE_W +: BYTE_W] = sbox(in_w[b*BYTE_W +: BYTE_W]);
    end

endmodule

// File: rtl/aes_ks_nextword.sv
`timescale 1ns/1ps
module aes_ks_nextword
    import aes_ks_pkg::*;
(
    input  word_t prev_w,
    input  word_t back_w,
    input  byte_t rcon,
    input  logic  at_key_start,
    input  logic  at_half,
    output word_t next_w
);
    word_t sub_in;
    word_t sub_out;
    word_t temp;

    assign sub_in = at_key_start ? rot_word(prev_w) : prev_w;

    aes_ks_subword u_sub (
        .in_w  (sub_in),
        .out_w (sub_out)
    );

    always_comb begin
        if (at_key_start)
            temp = sub_out ^ {rcon, {(WORD_W-BYTE_W){1'b0}}};
        else if (at_half)
            temp = sub_out;
        else
            temp = prev_w;
    end

    assign next_w = back_w ^ temp;

endmodule

// File: rtl/aes_ks_invmix.sv
`timescale 1ns/1ps
module aes_ks_invmix
    import aes_ks_pkg::*;
(
    input  word_t in_w,
    output word_t out_w
);
    localparam int LANES = WORD_W / BYTE_W;
    localparam byte_t COEF [LANES] = '{8'h0e, 8'h0b, 8'h0d, 8'h09};

    for (genvar r = 0; r < LANES; r++) begin : g_row
        byte_t acc;
        always_comb begin
            acc = '0;
            for (int k = 0; k < LANES; k++)
                acc = acc ^ gf_mul(in_w[WORD_W-1-k*BYTE_W -: BYTE_W],
                                   COEF[(k - r + LANES) % LANES]);
        end
        assign out_w[WORD_W-1-r*BYTE_W -: BYTE_W] = acc;
    end

endmodule

// File: rtl/aes_ks_store.sv
`timescale 1ns/1ps
module aes_ks_store
    import aes_ks_pkg::*;
#(
    parameter int DEPTH = MAX_WORDS,
    parameter int AW    = IDX_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wr_idx,
    input  word_t         wr_data,
    input  logic [AW-1:0] ra_idx,
    output word_t         ra_data,
    input  logic [AW-1:0] rb_idx,
    output word_t         rb_data
);
    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wr_idx] <= wr_data;
    end

    assign ra_data = (ra_idx < AW'(DEPTH)) ? mem[ra_idx] : '0;
    assign rb_data = (rb_idx < AW'(DEPTH)) ? mem[rb_idx] : '0;

endmodule

// File: rtl/aes_key_schedule.sv
`timescale 1ns/1ps
module aes_key_schedule
    import aes_ks_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        key_size,
    input  logic              decrypt,
    input  logic [KEY_W-1:0]  key_in,
    output logic              busy,
    output logic              done,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);
    ks_state_e        state_q;
    ks_geom_t         geom_q;
    logic             dec_q;
    logic [KEY_W-1:0] key_q;
    logic [IDX_W-1:0] idx_q;
    logic [POS_W-1:0] pos_q;
    byte_t            rcon_q;
    word_t            win_q [MAX_NK];

    word_t            key_word [MAX_NK];
    logic [POS_W-1:0] pos_last;
    logic [IDX_W-1:0] idx_last;
    logic [IDX_W-1:0] imc_last;
    logic             at_key_start;
    logic             at_half;
    word_t            next_w;
    word_t            imc_in;
    word_t            imc_out;
    logic             wr_en;
    word_t            wr_data;

    for (genvar k = 0; k < MAX_NK; k++) begin : g_keyword
        assign key_word[k] = key_q[KEY_W-1-k*WORD_W -: WORD_W];
    end

    assign pos_last     = POS_W'(geom_q.nk - NK_W'(1));
    assign idx_last     = geom_q.total - IDX_W'(1);
    assign imc_last     = geom_q.total - IDX_W'(ROUND_WORDS + 1);
    assign at_key_start = (pos_q == '0);
    assign at_half      = (geom_q.nk == NK_W'(MAX_NK)) && (pos_q == POS_W'(MAX_NK / 2));

    aes_ks_nextword u_next (
        .prev_w       (win_q[0]),
        .back_w       (win_q[pos_last]),
        .rcon         (rcon_q),
        .at_key_start (at_key_start),
        .at_half      (at_half),
        .next_w       (next_w)
    );

    aes_ks_invmix u_imc (
        .in_w  (imc_in),
        .out_w (imc_out)
    );

    aes_ks_store #(.DEPTH(MAX_WORDS), .AW(IDX_W)) u_store (
        .clk     (clk),
        .we      (wr_en),
        .wr_idx  (idx_q),
        .wr_data (wr_data),
        .ra_idx  (rd_idx),
        .ra_data (rd_word),
        .rb_idx  (idx_q),
        .rb_data (imc_in)
    );

    always_comb begin
        wr_en   = 1'b0;
        wr_data = next_w;
        case (state_q)
            KS_LOAD: begin
                wr_en   = 1'b1;
                wr_data = key_word[idx_q[POS_W-1:0]];
            end
            KS_EXPAND: wr_en = 1'b1;
            KS_IMC: begin
                wr_en   = 1'b1;
                wr_data = imc_out;
            end
            default: wr_en = 1'b0;
        endcase
    end

    assign busy = (state_q == KS_LOAD) || (state_q == KS_EXPAND) || (state_q == KS_IMC);
    assign done = (state_q == KS_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= KS_IDLE;
            geom_q  <= '0;
            dec_q   <= 1'b0;
            key_q   <= '0;
            idx_q   <= '0;
            pos_q   <= '0;
            rcon_q  <= RCON_FIRST;
            for (int k = 0; k < MAX_NK; k++) win_q[k] <= '0;
        end else begin
            case (state_q)
                KS_IDLE, KS_DONE: begin
                    if (start) begin
                        geom_q  <= geom_of(key_size);
                        dec_q   <= decrypt;
                        key_q   <= key_in;
                        idx_q   <= '0;
                        pos_q   <= '0;
                        rcon_q  <= RCON_FIRST;
                        state_q <= KS_LOAD;
                    end else begin
                        state_q <= KS_IDLE;
                    end
                end
                KS_LOAD, KS_EXPAND: begin
                    for (int k = MAX_NK - 1; k > 0; k--) win_q[k] <= win_q[k-1];
                    win_q[0] <= wr_data;
                    if (state_q == KS_EXPAND && at_key_start) rcon_q <= xtime(rcon_q);
                    pos_q <= (pos_q == pos_last) ? '0 : pos_q + POS_W'(1);
                    if (idx_q == idx_last) begin
                        if (dec_q) begin
                            idx_q   <= IDX_W'(IMC_FIRST);
                            state_q <= KS_IMC;
                        end else begin
                            state_q <= KS_DONE;
                        end
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                        if (pos_q == pos_last) state_q <= KS_EXPAND;
                    end
                end
                KS_IMC: begin
                    if (idx_q == imc_last) state_q <= KS_DONE;
                    else                   idx_q   <= idx_q + IDX_W'(1);
                end
                default: state_q <= KS_IDLE;
            endcase
        end
    end

    // R1: no write lands beyond the schedule length of the captured size
    assert_write_in_range_R1: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (idx_q <= idx_last));

    // R6: the mixing pass touches only the middle round keys
    assert_imc_window_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == KS_IMC) |-> (idx_q >= IDX_W'(IMC_FIRST)) && (idx_q <= imc_last));

    // R3: the round constant moves only on a rotate-substitute word
    assert_rcon_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == KS_EXPAND && !at_key_start) |=> $stable(rcon_q));

    // R8: a running job keeps its captured configuration
    assert_cfg_held_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(geom_q) && $stable(dec_q) && $stable(key_q)));

    // R9: completion is a single-cycle pulse outside busy
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(busy) && !busy));

endmodule

// File: tb/aes_key_schedule_bench.sv
`timescale 1ns/1ps
module aes_key_schedule_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [1:0]   key_size = 2'd0;
    logic         decrypt = 1'b0;
    logic [255:0] key_in = '0;
    logic [5:0]   rd_idx = '0;
    logic         busy;
    logic         done;
    logic [31:0]  rd_word;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [31:0] ref_w [60];
    logic [31:0] enc_w [60];

    // behavioural timing model
    bit m_busy = 0;
    bit m_done = 0;
    int m_cnt = 0;

    always #2.5 clk = ~clk;

    aes_key_schedule u_aes_key_schedule (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .key_size (key_size),
        .decrypt  (decrypt),
        .key_in   (key_in),
        .busy     (busy),
        .done     (done),
        .rd_idx   (rd_idx),
        .rd_word  (rd_word)
    );

    function automatic int rounds_of(input logic [1:0] s);
        return (s == 2'd0) ? 10 : (s == 2'd1) ? 12 : 14;
    endfunction

    function automatic int latency(input logic [1:0] s, input bit d);
        return d ? 8 * rounds_of(s) : 4 * rounds_of(s) + 4;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_cnt = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin m_busy = 0; m_done = 1; end
            end else if (start) begin
                m_busy = 1;
                m_cnt = latency(key_size, decrypt);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R7 R9 compared on every clock
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(busy == m_busy, "R7 busy vs model", 32'(busy), 32'(m_busy));
            chk(done == m_done, "R9 done vs model", 32'(done), 32'(m_done));
        end
    end

    // independent field arithmetic: MSB-first shift and reduce
    function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] p;
        p = '0;
        for (int k = 7; k >= 0; k--) begin
            p = p << 1;
            if (p[8]) p = p ^ 9'h11b;
            if (b[k]) p = p ^ {1'b0, a};
        end
        return p[7:0];
    endfunction

    function automatic logic [7:0] b_sbox(input logic [7:0] x);
        logic [7:0] inv;
        logic [7:0] c;
        logic [7:0] s;
        inv = '0;
        for (int v = 1; v < 256; v++)
            if (b_mul(x, 8'(v)) == 8'h01) inv = 8'(v);
        c = 8'h63;
        for (int i = 0; i < 8; i++)
            s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
        return s;
    endfunction

    function automatic logic [31:0] b_subw(input logic [31:0] w);
        return {b_sbox(w[31:24]), b_sbox(w[23:16]), b_sbox(w[15:8]), b_sbox(w[7:0])};
    endfunction

    function automatic logic [31:0] b_imc(input logic [31:0] w);
        logic [7:0] a0, a1, a2, a3;
        a0 = w[31:24]; a1 = w[23:16]; a2 = w[15:8]; a3 = w[7:0];
        return {b_mul(a0,8'h0e)^b_mul(a1,8'h0b)^b_mul(a2,8'h0d)^b_mul(a3,8'h09),
                b_mul(a0,8'h09)^b_mul(a1,8'h0e)^b_mul(a2,8'h0b)^b_mul(a3,8'h0d),
                b_mul(a0,8'h0d)^b_mul(a1,8'h09)^b_mul(a2,8'h0e)^b_mul(a3,8'h0b),
                b_mul(a0,8'h0b)^b_mul(a1,8'h0d)^b_mul(a2,8'h09)^b_mul(a3,8'h0e)};
    endfunction

    task automatic build_ref(input logic [255:0] key, input logic [1:0] sz, input bit dec);
        int nk;
        int tot;
        logic [7:0] rc;
        logic [31:0] t;
        nk  = rounds_of(sz) - 6;
        tot = 4 * (rounds_of(sz) + 1);
        rc  = 8'h01;
        for (int i = 0; i < nk; i++) ref_w[i] = key[255-32*i -: 32];
        for (int i = nk; i < tot; i++) begin
            t = ref_w[i-1];
            if (i % nk == 0) begin
                t = b_subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
                rc = b_mul(rc, 8'h02);
            end else if (nk == 8 && i % nk == 4) begin
                t = b_subw(t);
            end
            ref_w[i] = ref_w[i-nk] ^ t;
        end
        for (int i = 0; i < tot; i++) enc_w[i] = ref_w[i];
        if (dec)
            for (int i = 4; i < tot - 4; i++) ref_w[i] = b_imc(ref_w[i]);
    endtask

    task automatic launch(input logic [255:0] key, input logic [1:0] sz, input bit dec);
        @(negedge clk);
        key_in = key; key_size = sz; decrypt = dec; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int cyc;
        cyc = 0;
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        chk(done, "R7 completion reached", 32'(done), 32'd1);
    endtask

    task automatic compare_all(input logic [1:0] sz, input string req);
        int tot;
        tot = 4 * (rounds_of(sz) + 1);
        for (int i = 0; i < tot; i++) begin
            rd_idx = 6'(i);
            #0.1;
            chk(rd_word == ref_w[i], req, rd_word, ref_w[i]);
        end
    endtask

    task automatic read_word(input int i, output logic [31:0] w);
        rd_idx = 6'(i);
        #0.1;
        w = rd_word;
    endtask

    localparam logic [255:0] KEY128 = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
    localparam logic [255:0] KEY192 = {192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 64'h0};
    localparam logic [255:0] KEY256 = 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;

    task automatic report();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(busy == 1'b0, "R10 busy after reset", 32'(busy), 32'd0);
        chk(done == 1'b0, "R10 done after reset", 32'(done), 32'd0);

        // R11 R2 R3 R5: 128-bit vector, encryption order
        build_ref(KEY128, 2'd0, 0);
        launch(KEY128, 2'd0, 0);
        wait_done();
        compare_all(2'd0, "R2 R3 R5 word 128");
        read_word(43, w);
        chk(w == 32'hb6630ca6, "R11 last word 128", w, 32'hb6630ca6);
        read_word(0, w);
        chk(w == 32'h2b7e1516, "R2 R10 word 0 via read port", w, 32'h2b7e1516);

        // R1 R11: 192-bit vector
        build_ref(KEY192, 2'd1, 0);
        launch(KEY192, 2'd1, 0);
        wait_done();
        compare_all(2'd1, "R1 R3 R5 word 192");
        read_word(51, w);
        chk(w == 32'h01002202, "R11 last word 192", w, 32'h01002202);

        // R4 R11: 256-bit vector
        build_ref(KEY256, 2'd2, 0);
        launch(KEY256, 2'd2, 0);
        wait_done();
        compare_all(2'd2, "R4 R3 R5 word 256");
        read_word(12, w);
        chk(w == ref_w[12], "R4 substitution-only word 12", w, ref_w[12]);
        read_word(59, w);
        chk(w == 32'h706c631e, "R11 last word 256", w, 32'h706c631e);

        // R5: all-zero key, substitution of zero is 0x63
        build_ref('0, 2'd0, 0);
        launch('0, 2'd0, 0);
        wait_done();
        read_word(4, w);
        chk(w == 32'h62636363, "R5 zero key word 4", w, 32'h62636363);
        compare_all(2'd0, "R5 zero key word");

        // R6: decryption order, 128-bit
        build_ref(KEY128, 2'd0, 1);
        launch(KEY128, 2'd0, 1);
        wait_done();
        compare_all(2'd0, "R6 dec word 128");
        read_word(3, w);
        chk(w == enc_w[3], "R6 first round key unchanged", w, enc_w[3]);
        read_word(40, w);
        chk(w == enc_w[40], "R6 last round key unchanged", w, enc_w[40]);
        read_word(4, w);
        chk(w == b_imc(enc_w[4]), "R6 word 4 mixed", w, b_imc(enc_w[4]));

        // R6 R1: decryption order, size code 3 acts as 256-bit
        build_ref(KEY256, 2'd3, 1);
        launch(KEY256, 2'd3, 1);
        wait_done();
        compare_all(2'd3, "R1 R6 dec word size3");

        // R8: start during busy is ignored
        build_ref(KEY192, 2'd1, 0);
        launch(KEY192, 2'd1, 0);
        repeat (6) @(negedge clk);
        key_in = KEY128; key_size = 2'd0; decrypt = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8 still busy after stray start", 32'(busy), 32'd1);
        wait_done();
        compare_all(2'd1, "R8 words of first job kept");

        repeat (3) @(negedge clk);
        report();
    end

endmodule